// File: doc/BRIEF.md
# Shift and Rotate Unit with Extend Flag

This unit carries out one shift or rotate on a byte, word or long-word operand in each clock cycle. There are four operation classes: arithmetic shift, logical shift, plain rotate, and rotate through the extend bit. Each class can move bits left or right. The shift count comes from one of two places:

- a 3-bit immediate field, where the code 0 means a count of 8;
- a register value, of which only the low six bits are used.

Along with the operand and the count, the unit takes the current extend flag. It returns the shifted operand, a new extend flag and four condition flags (negative, zero, overflow, carry).

The unit is meant to sit in the execute stage of a processor datapath. Decode supplies the class, direction, size and count source. Bits of the operand above the selected size pass through unchanged, so the result can be written straight back to a 32-bit register. All outputs are registered, so a result appears one clock after its inputs are presented.

Top module: `shift_rotate_unit`

## Requirements
- R1: The count is `imm_cnt` when `cnt_sel_reg`=0, with code 0 meaning 8. It is `reg_cnt` modulo 64 when `cnt_sel_reg`=1.
- R2: Arithmetic left shift (`op_kind`=00, `dir_left`=1) fills vacated low bits with zeros. C and X take the last bit shifted out. V is 1 if the size-MSB changes at any step of the shift.
- R3: Arithmetic right shift (`op_kind`=00, `dir_left`=0) copies the size-MSB into the vacated high bits. C and X take the last bit shifted out.
- R4: Logical shifts (`op_kind`=01) zero-fill in both directions. C and X take the last bit shifted out.
- R5: Plain rotates (`op_kind`=10) move each bit that leaves one end into the other end, and wrap for counts larger than the size. C takes the last bit rotated out. X is left equal to `x_in`.
- R6: Rotate through extend (`op_kind`=11) rotates a ring of size+1 bits, with X as the extra bit. On a right step, bit 0 goes to X and the old X goes to the size-MSB. X and C take the last bit rotated out.
- R7: With an effective count of zero, the result equals the operand, X equals `x_in` and V is 0. C is 0, except for rotate through extend, where C equals `x_in`.
- R8: N is the result bit at the size-MSB and Z is 1 when the result bits within the size are all zero. V is 0 for every operation other than an arithmetic left shift.
- R9: Result bits above the selected size (`size`: 00 byte, 01 word, 10 or 11 long) equal the operand bits.
- R10: All outputs are registered, one clock after the inputs. While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_kind | input | 2 | 00 arithmetic, 01 logical, 10 rotate, 11 rotate through extend |
| dir_left | input | 1 | 1 shifts left, 0 shifts right |
| size | input | 2 | 00 byte, 01 word, 10/11 long word |
| cnt_sel_reg | input | 1 | 1 takes the count from reg_cnt, 0 from imm_cnt |
| imm_cnt | input | 3 | Immediate count, 0 meaning 8 |
| reg_cnt | input | 32 | Register count, used modulo 64 |
| operand | input | 32 | Value to shift |
| x_in | input | 1 | Current extend flag |
| result | output | 32 | Shifted value |
| x_out | output | 1 | New extend flag |
| n_out | output | 1 | Negative flag |
| z_out | output | 1 | Zero flag |
| v_out | output | 1 | Overflow flag |
| c_out | output | 1 | Carry flag |

## Verification
Every result and flag comes from the inputs through a single register stage. The value presented before a rising edge therefore appears on the outputs just after that edge. The bench drives inputs on the falling edge, lets one rising edge pass, and samples on the next falling edge, which is exactly one cycle later and away from the active edge. The directed cases cover:

- counts above the operand width;
- counts that wrap modulo 64;
- the immediate code for 8;
- full-ring rotations that return the operand unchanged.

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit #(
  parameter int DW = 32,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    op_kind,
  input  logic          dir_left,
  input  logic [1:0]    size,
  input  logic          cnt_sel_reg,
  input  logic [2:0]    imm_cnt,
  input  logic [DW-1:0] reg_cnt,
  input  logic [DW-1:0] operand,
  input  logic          x_in,
  output logic [DW-1:0] result,
  output logic          x_out,
  output logic          n_out,
  output logic          z_out,
  output logic          v_out,
  output logic          c_out
);
  localparam int STEPS = 1 << CW;
  localparam logic [1:0] K_ARI = 2'b00, K_ROT = 2'b10, K_ROX = 2'b11;

  logic [CW:0]    cnt;
  logic [4:0]     msb;
  logic [DW-1:0]  mask, val;
  logic           rx, cy, ov, outb, fill;
  logic           unused_bits;

  assign unused_bits = ^reg_cnt[DW-1:CW];
  assign cnt = cnt_sel_reg ? {1'b0, reg_cnt[CW-1:0]}
                           : (imm_cnt == 3'd0 ? (CW+1)'(8) : (CW+1)'(imm_cnt));

  always_comb begin
    case (size)
      2'b00:   begin msb = 5'd7;  mask = DW'(32'h0000_00FF); end
      2'b01:   begin msb = 5'd15; mask = DW'(32'h0000_FFFF); end
      default: begin msb = 5'd31; mask = '1; end
    endcase
  end

  always_comb begin
    val = operand & mask;
    rx = x_in;
    cy = 1'b0;
    ov = 1'b0;
    outb = 1'b0;
    fill = 1'b0;
    for (int i = 0; i < STEPS; i++) begin
      if ((CW+1)'(i) < cnt) begin
        if (dir_left) begin
          outb = val[msb];
          if (op_kind == K_ARI && val[msb] != val[msb - 5'd1]) ov = 1'b1;
          fill = (op_kind == K_ROT) ? val[msb] : (op_kind == K_ROX) ? rx : 1'b0;
          val = ((val << 1) | DW'(fill)) & mask;
        end else begin
          outb = val[0];
          fill = (op_kind == K_ARI) ? val[msb] : (op_kind == K_ROT) ? val[0] :
                 (op_kind == K_ROX) ? rx : 1'b0;
          val = (val >> 1) | (DW'(fill) << msb);
        end
        if (op_kind == K_ROX) rx = outb;
        cy = outb;
      end
    end
  end

  logic zc;
  assign zc = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      x_out  <= 1'b0;
      n_out  <= 1'b0;
      z_out  <= 1'b0;
      v_out  <= 1'b0;
      c_out  <= 1'b0;
    end else begin
      result <= (operand & ~mask) | val;
      x_out  <= (zc || op_kind == K_ROT) ? x_in : cy;
      c_out  <= zc ? (op_kind == K_ROX && x_in) : cy;
      v_out  <= ov;
      n_out  <= val[msb];
      z_out  <= (val == '0);
    end
  end

  p_zero_count_c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(zc) && $past(op_kind) != K_ROX |-> !c_out);
  p_zero_count_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(zc) |-> result == $past(operand) && x_out == $past(x_in));
  p_rotate_keeps_x_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(op_kind) == K_ROT |-> x_out == $past(x_in));
  p_v_only_asl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !($past(op_kind) == K_ARI && $past(dir_left)) |-> !v_out);
  p_byte_upper_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(size) == 2'b00 |-> result[DW-1:8] == $past(operand[DW-1:8]));
  p_zero_not_neg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    z_out |-> !n_out);
  p_shift_x_eq_c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(op_kind) == 2'b01 && !$past(zc) |-> x_out == c_out);
endmodule

// File: tb/shift_rotate_unit_tb.sv
module shift_rotate_unit_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] op_kind = '0, size = '0;
  logic dir_left = 1'b0, cnt_sel_reg = 1'b0, x_in = 1'b0;
  logic [2:0] imm_cnt = '0;
  logic [31:0] reg_cnt = '0, operand = '0, result;
  logic x_out, n_out, z_out, v_out, c_out;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  shift_rotate_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_kind(op_kind), .dir_left(dir_left), .size(size),
    .cnt_sel_reg(cnt_sel_reg), .imm_cnt(imm_cnt), .reg_cnt(reg_cnt), .operand(operand),
    .x_in(x_in), .result(result), .x_out(x_out), .n_out(n_out), .z_out(z_out),
    .v_out(v_out), .c_out(c_out));

  task automatic chk(string req, logic [36:0] act, logic [36:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h (result,X,N,Z,V,C)", req, act, exp);
    end
  endtask

  task automatic run(string req, logic [1:0] k, logic l, logic [1:0] s, logic sel,
                     logic [2:0] imm, logic [31:0] rc, logic [31:0] op, logic xi,
                     logic [31:0] er, logic [4:0] ef);
    @(negedge clk);
    op_kind = k; dir_left = l; size = s; cnt_sel_reg = sel; imm_cnt = imm;
    reg_cnt = rc; operand = op; x_in = xi;
    @(negedge clk);
    chk(req, {result, x_out, n_out, z_out, v_out, c_out}, {er, ef});
  endtask

  // flags order: X N Z V C
  task automatic t_reset();
    chk("R10 reset", {result, x_out, n_out, z_out, v_out, c_out}, '0);
  endtask
  task automatic t_asl();
    run("R2 asl byte #3", 2'b00, 1, 2'b00, 0, 3'd3, 0, 32'hAABBCC17, 1, 32'hAABBCCB8, 5'b01010);
    run("R2 asl no ovf carry", 2'b00, 1, 2'b00, 0, 3'd1, 0, 32'h000000C0, 0, 32'h00000080, 5'b11001);
    run("R2 asl ovf", 2'b00, 1, 2'b00, 0, 3'd1, 0, 32'h00000040, 0, 32'h00000080, 5'b01010);
    run("R2 asl byte count 9", 2'b00, 1, 2'b00, 1, 3'd0, 32'd9, 32'h00000001, 1, 32'h00000000, 5'b00110);
  endtask
  task automatic t_asr();
    run("R3 asr sign fill", 2'b00, 0, 2'b00, 0, 3'd3, 0, 32'h000000E9, 1, 32'h000000FD, 5'b01000);
    run("R3 asr positive", 2'b00, 0, 2'b00, 0, 3'd3, 0, 32'h00000017, 0, 32'h00000002, 5'b10001);
    run("R3 asr word count 20", 2'b00, 0, 2'b01, 1, 3'd0, 32'd20, 32'h00008000, 0, 32'h0000FFFF, 5'b11001);
  endtask
  task automatic t_logical();
    run("R4 lsr word reg 4", 2'b01, 0, 2'b01, 1, 3'd0, 32'd4, 32'h12348428, 0, 32'h12340842, 5'b10001);
    run("R4 lsl long count 32", 2'b01, 1, 2'b10, 1, 3'd0, 32'd32, 32'h00000001, 0, 32'h00000000, 5'b10101);
    run("R1 reg count 65 mod 64", 2'b01, 1, 2'b00, 1, 3'd0, 32'd65, 32'h00000081, 0, 32'h00000002, 5'b10001);
  endtask
  task automatic t_rotate();
    run("R1 imm 0 is 8 rol", 2'b10, 1, 2'b00, 0, 3'd0, 0, 32'h000000A5, 0, 32'h000000A5, 5'b01001);
    run("R5 ror long", 2'b10, 0, 2'b10, 0, 3'd1, 0, 32'h00000001, 0, 32'h80000000, 5'b01001);
  endtask
  task automatic t_rotx();
    run("R6 roxr x into msb", 2'b11, 0, 2'b00, 0, 3'd1, 0, 32'h00000000, 1, 32'h00000080, 5'b01000);
    run("R6 roxr bit0 into x", 2'b11, 0, 2'b00, 0, 3'd1, 0, 32'h00000001, 0, 32'h00000000, 5'b10101);
    run("R6 roxl word ring 17", 2'b11, 1, 2'b01, 1, 3'd0, 32'd17, 32'h00001234, 1, 32'h00001234, 5'b10001);
  endtask
  task automatic t_zero_count();
    run("R7 lsr count 64 is zero", 2'b01, 0, 2'b10, 1, 3'd0, 32'd64, 32'h80000000, 1, 32'h80000000, 5'b11000);
    run("R7 roxl zero c=x", 2'b11, 1, 2'b00, 1, 3'd0, 32'd0, 32'h00000000, 1, 32'h00000000, 5'b10101);
    run("R7 asl zero count", 2'b00, 1, 2'b00, 1, 3'd0, 32'd0, 32'h00000040, 0, 32'h00000040, 5'b00000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_asl();
    t_asr();
    t_logical();
    t_rotate();
    t_rotx();
    t_zero_count();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule